// File: doc/BRIEF.md
# Grayscale LED Driver Chain Refresh Controller

This block feeds a daisy chain of serial-input LED driver chips. Each chip has sixteen outputs with a 12-bit grayscale level. The block keeps one 12-bit level for every output in the chain. A host sets those levels one at a time through a simple write port.

The block also runs the refresh. It produces the grayscale clock and counts a fixed number of its periods per PWM cycle. At the end of each cycle it stops that clock and raises the blanking output. Between cycles it pulses the latch so that a fully shifted frame reaches the outputs. The serial data leaves as one long MSB-first stream, with the highest-numbered output first.

A mode input picks one of two schedules. In the default schedule, a frame shifts while the grayscale cycle runs. It is sent only when a level has changed, and it is latched at the next blanking interval. In the stretched schedule, a frame is sent on every cycle, entirely inside the blanking interval, which is held until the frame has been latched. Out of reset, the block keeps the outputs blanked and clears the chain with an oversized frame of zeros before cycling starts.

Top module: `gs_chain_refresh`

## Requirements
- R1: While reset is held, and afterwards until the first latch pulse, `blank` is 1 and `xlat`, `gsclk` and `sclk` are 0. The first latch follows a clear frame of 200 zero bits per chip. Because the level store starts marked as changed, an all-zero frame of normal length follows.
- R2: Each PWM cycle, counted from the fall of `blank` to its next rise, contains exactly GS_STEPS rising edges of `gsclk`. `gsclk` stays low whenever `blank` is 1.
- R3: A normal frame is 192 bits per chip, sent MSB first. `sout` changes only while `sclk` is low and is valid at the rising edge of `sclk`. The outputs go out from index 16·N−1 down to 0. Outputs 2p+1 and 2p form three bytes in this order: odd[11:4], then {odd[3:0], even[11:8]}, then even[7:0].
- R4: `xlat` is a single system-clock pulse. It occurs only while `blank` is 1 and while `sclk` and `gsclk` are low. `blank` is still 1 in the cycle after the pulse.
- R5: A latch occurs only after a complete frame has finished shifting since the previous latch. In the default schedule, when no valid write has happened, no frame and no latch occur.
- R6: With `mode_alt` = 0, a frame begins when `blank` falls, and every bit of it is clocked while `blank` is 0. That frame is latched in the following blanking interval.
- R7: With `mode_alt` = 1, every blanking interval carries a full frame of the current levels, even when nothing changed. All bits are clocked while `blank` is 1, and the latch comes before `blank` falls.
- R8: A write whose `wr_idx` is 16·N or greater changes no level and does not cause a frame to be sent.
- R9: A write that arrives while a frame is shifting does not alter that frame. The write appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_alt | input | 1 | 0: shift during the grayscale cycle; 1: shift inside a stretched blanking interval |
| wr_en | input | 1 | Level write strobe |
| wr_idx | input | IDX_W | Output index to write |
| wr_data | input | 12 | 12-bit grayscale level |
| gsclk | output | 1 | Grayscale clock to the chain |
| blank | output | 1 | Blanking; high ends the PWM cycle |
| sclk | output | 1 | Serial data clock (idle low) |
| sout | output | 1 | Serial data, MSB first |
| xlat | output | 1 | Latch pulse for the shifted frame |

## Verification
The bench builds the block with one chip, a 256-step PWM cycle, and both dividers at one system clock per half period. A PWM cycle is then about 520 clocks and a frame 384 clocks. This allows twenty-odd PWM cycles in a short run: a batch that rewrites all sixteen outputs, writes that fall mid-frame, and several cycles in each schedule, including the switch back with nothing pending. With a single chip, index 16 is already out of range, so the ignored-write rule can be reached with small indices.

// File: rtl/gsdrv_pkg.sv
package gsdrv_pkg;
  localparam int CH_PER_CHIP    = 16;
  localparam int LVL_W          = 12;
  localparam int CLEAR_PAD_BITS = 8;

  // serial bits of one refresh frame for a chain of nchips
  function automatic int frame_bits(input int nchips);
    return nchips * CH_PER_CHIP * LVL_W;
  endfunction

  // startup clear frame: one extra byte per chip
  function automatic int clear_bits(input int nchips);
    return frame_bits(nchips) + nchips * CLEAR_PAD_BITS;
  endfunction

  typedef enum logic [2:0] {
    ST_CLEAR, ST_CLRWAIT, ST_BLANK, ST_FILL, ST_LATCH, ST_GAP, ST_RUN
  } seq_state_t;
endpackage

// File: rtl/gs_level_store.sv
module gs_level_store
  import gsdrv_pkg::*;
#(
  parameter int NOUT  = 64,
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [LVL_W-1:0]       wr_data,
  output logic                   wr_ok,
  output logic [NOUT*LVL_W-1:0]  levels_flat
);
  localparam int SEL_W = $clog2(NOUT);

  logic [LVL_W-1:0] shadow [NOUT];

  assign wr_ok = wr_en && (int'(wr_idx) < NOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NOUT; i++) shadow[i] <= '0;
    end else if (wr_ok) begin
      shadow[wr_idx[SEL_W-1:0]] <= wr_data;
    end
  end

  // output k occupies bits [12k+11:12k]; the top bit leaves the wire first
  for (genvar g = 0; g < NOUT; g++) begin : g_flat
    assign levels_flat[g*LVL_W +: LVL_W] = shadow[g];
  end

  assert_ignore_oob_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> $stable(levels_flat));
endmodule

// File: rtl/gs_frame_shifter.sv
module gs_frame_shifter
  import gsdrv_pkg::*;
#(
  parameter int NCHIP    = 4,
  parameter int SCK_HALF = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          clear_frame,
  input  logic [frame_bits(NCHIP)-1:0]  frame_in,
  output logic                          sclk,
  output logic                          sout,
  output logic                          busy,
  output logic                          done
);
  localparam int FB    = frame_bits(NCHIP);
  localparam int CB    = clear_bits(NCHIP);
  localparam int PAD   = CB - FB;
  localparam int CNT_W = $clog2(CB + 1);
  localparam int DIV_W = $clog2(SCK_HALF + 1);

  logic [CB-1:0]    sr;
  logic [CNT_W-1:0] left;
  logic [DIV_W-1:0] div;

  wire half_done = (div == DIV_W'(SCK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; left <= '0; div <= '0;
      sclk <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sr   <= clear_frame ? '0 : {frame_in, {PAD{1'b0}}};
        left <= clear_frame ? CNT_W'(CB) : CNT_W'(FB);
        busy <= 1'b1;
        div  <= '0;
        sclk <= 1'b0;
      end else if (busy) begin
        if (half_done) begin
          div <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            sr   <= sr << 1;
            if (left == CNT_W'(1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              left <= left - CNT_W'(1);
            end
          end
        end else begin
          div <= div + DIV_W'(1);
        end
      end
    end
  end

  assign sout = busy & sr[CB-1];

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/gs_cycle_timer.sv
module gs_cycle_timer #(
  parameter int GS_STEPS = 4096,
  parameter int GS_HALF  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic gsclk,
  output logic cyc_end
);
  localparam int STEP_W = $clog2(GS_STEPS + 1);
  localparam int DIV_W  = $clog2(GS_HALF + 1);

  logic [STEP_W-1:0] steps;
  logic [DIV_W-1:0]  div;

  wire tick = run && (div == DIV_W'(GS_HALF - 1));
  // the last falling edge of the cycle closes it
  assign cyc_end = tick && gsclk && (steps == STEP_W'(GS_STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0; steps <= '0; gsclk <= 1'b0;
    end else if (!run) begin
      div <= '0; steps <= '0; gsclk <= 1'b0;
    end else if (tick) begin
      div   <= '0;
      gsclk <= !gsclk;
      if (gsclk) steps <= steps + STEP_W'(1);
    end else begin
      div <= div + DIV_W'(1);
    end
  end

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= STEP_W'(GS_STEPS));
  assert_stop_on_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !run);
endmodule

// File: rtl/gs_chain_refresh.sv
module gs_chain_refresh
  import gsdrv_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int GS_STEPS  = 4096,
  parameter int GS_HALF   = 4,
  parameter int SCK_HALF  = 2,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_alt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [11:0]      wr_data,
  output logic             gsclk,
  output logic             blank,
  output logic             sclk,
  output logic             sout,
  output logic             xlat
);
  localparam int NOUT = NUM_CHIPS * CH_PER_CHIP;
  localparam int FB   = frame_bits(NUM_CHIPS);

  seq_state_t state, state_nx;
  logic dirty, latch_pend;

  // named internal events
  logic          wr_ok, sh_start, sh_clear, sh_busy, sh_done, cyc_end, gs_run, frame_snap;
  logic [FB-1:0] levels_flat;

  gs_level_store #(.NOUT(NOUT), .IDX_W(IDX_W)) u_store (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .wr_ok, .levels_flat
  );

  gs_frame_shifter #(.NCHIP(NUM_CHIPS), .SCK_HALF(SCK_HALF)) u_shift (
    .clk, .rst_n, .start(sh_start), .clear_frame(sh_clear), .frame_in(levels_flat),
    .sclk, .sout, .busy(sh_busy), .done(sh_done)
  );

  gs_cycle_timer #(.GS_STEPS(GS_STEPS), .GS_HALF(GS_HALF)) u_timer (
    .clk, .rst_n, .run(gs_run), .gsclk, .cyc_end
  );

  always_comb begin
    sh_start = 1'b0;
    sh_clear = 1'b0;
    state_nx = state;
    unique case (state)
      ST_CLEAR:   begin sh_start = 1'b1; sh_clear = 1'b1; state_nx = ST_CLRWAIT; end
      ST_CLRWAIT: if (sh_done) state_nx = ST_LATCH;
      ST_BLANK: begin
        if (mode_alt) begin
          if (!sh_busy) begin sh_start = 1'b1; state_nx = ST_FILL; end
        end else begin
          state_nx = latch_pend ? ST_LATCH : ST_GAP;
        end
      end
      ST_FILL:    if (sh_done) state_nx = ST_LATCH;
      ST_LATCH:   state_nx = ST_GAP;
      ST_GAP: begin
        sh_start = !mode_alt && dirty && !sh_busy;
        state_nx = ST_RUN;
      end
      ST_RUN:     if (cyc_end) state_nx = ST_BLANK;
      default:    state_nx = ST_CLEAR;
    endcase
  end

  assign frame_snap = sh_start && !sh_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_CLEAR;
      dirty      <= 1'b1;
      latch_pend <= 1'b0;
    end else begin
      state <= state_nx;
      if (wr_ok)           dirty <= 1'b1;
      else if (frame_snap) dirty <= 1'b0;
      if (sh_done)                latch_pend <= 1'b1;
      else if (state == ST_LATCH) latch_pend <= 1'b0;
    end
  end

  assign blank  = (state != ST_RUN);
  assign gs_run = (state == ST_RUN);
  assign xlat   = (state == ST_LATCH);

  assert_latch_has_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |-> (latch_pend && !sh_busy));
  assert_xlat_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |-> (!gsclk && !sclk));
  assert_xlat_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |=> (!xlat && blank));
  assert_gs_idle_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !gsclk);
endmodule

// File: tb/gs_chain_refresh_tb_top.sv
module gs_chain_refresh_tb_top;
  localparam int NC  = 1;
  localparam int GSS = 256;
  localparam int NO  = 16 * NC;
  localparam int FB  = 192 * NC;
  localparam int CB  = 200 * NC;
  localparam int IW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_alt = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [11:0] wr_data = '0;
  logic gsclk, blank, sclk, sout, xlat;

  always #5 clk = ~clk;

  gs_chain_refresh #(.NUM_CHIPS(NC), .GS_STEPS(GSS), .GS_HALF(1), .SCK_HALF(1), .IDX_W(IW)) dut_i (
    .clk, .rst_n, .mode_alt, .wr_en, .wr_idx, .wr_data, .gsclk, .blank, .sclk, .sout, .xlat
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // scoreboard state
  logic [FB-1:0] exp_frame_q[$];
  int            exp_len_q[$];
  bit            exp_blank_q[$];
  string         exp_tag_q[$];
  logic [11:0]   model [NO];
  logic [FB-1:0] model_frame = '0;
  bit            tb_alt = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // byte-pair view of the wire stream (R3)
  function automatic logic [FB-1:0] pack_model();
    logic [FB-1:0] v;
    logic [11:0] od, ev;
    v = '0;
    for (int p = NO/2 - 1; p >= 0; p--) begin
      od = model[2*p+1];
      ev = model[2*p];
      v = {v[FB-25:0], od[11:4], od[3:0], ev[11:8], ev[7:0]};
    end
    return v;
  endfunction

  task automatic push_exp(input string tag, input logic [FB-1:0] f, input int len, input bit inb);
    exp_frame_q.push_back(f);
    exp_len_q.push_back(len);
    exp_blank_q.push_back(inb);
    exp_tag_q.push_back(tag);
  endtask

  task automatic wr(input int idx, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    if (idx < NO) model[idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic end_batch(input string tag, input bit expect_frame);
    model_frame = pack_model();
    if (expect_frame) push_exp(tag, model_frame, FB, 1'b0);
  endtask

  task automatic wait_run_start();
    logic lb;
    lb = blank;
    @(negedge clk);
    while (!(lb && !blank)) begin
      lb = blank;
      @(negedge clk);
    end
  endtask

  // monitor
  logic prev_sclk, prev_gs, prev_blank, prev_xlat;
  logic [FB-1:0] shreg;
  int nbits, nbits_bl, gs_cnt, xlat_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 0; prev_gs = 0; prev_blank = 1; prev_xlat = 0;
      shreg = '0; nbits = 0; nbits_bl = 0; gs_cnt = 0; xlat_cnt = 0;
    end else begin
      if (sclk && !prev_sclk) begin
        shreg = {shreg[FB-2:0], sout};
        nbits++;
        if (blank) nbits_bl++;
      end
      if (gsclk && !prev_gs) gs_cnt++;
      if (blank && gsclk) chk("R2 gsclk high in blank", 1, 0);
      if (prev_blank && !blank) begin
        chk("R1 release after first latch", xlat_cnt > 0, 1);
        gs_cnt = 0;
      end
      if (!prev_blank && blank) chk("R2 gsclk edges per cycle", gs_cnt, GSS);
      if (prev_xlat && !blank) chk("R4 blank held after xlat", 0, 1);
      if (xlat && prev_xlat) chk("R4 xlat width", 2, 1);
      if (xlat && !prev_xlat) begin
        xlat_cnt++;
        chk("R4 xlat in blank", blank, 1);
        chk("R4 sclk low at xlat", sclk, 0);
        if (exp_frame_q.size() > 0) begin
          logic [FB-1:0] ef;
          int el;
          bit eb;
          string et;
          ef = exp_frame_q.pop_front(); el = exp_len_q.pop_front();
          eb = exp_blank_q.pop_front(); et = exp_tag_q.pop_front();
          n_cmp++;
          if (shreg !== ef) begin
            n_bad++;
            $display("FAIL R3 %s frame: actual %h expected %h", et, shreg, ef);
          end
          chk({"R5 bit count ", et}, nbits, el);
          chk({"R6 bits in blank ", et}, nbits_bl, eb ? el : 0);
        end else if (tb_alt) begin
          n_cmp++;
          if (shreg !== model_frame) begin
            n_bad++;
            $display("FAIL R7 frame: actual %h expected %h", shreg, model_frame);
          end
          chk("R7 bit count", nbits, FB);
          chk("R7 bits in blank", nbits_bl, FB);
        end else begin
          chk("R5 unexpected latch", 1, 0);
        end
        nbits = 0; nbits_bl = 0;
      end
      prev_sclk = sclk; prev_gs = gsclk; prev_blank = blank; prev_xlat = xlat;
    end
  end

  initial begin
    for (int i = 0; i < NO; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 blank in reset", blank, 1);
    chk("R1 xlat in reset", xlat, 0);
    chk("R1 gsclk in reset", gsclk, 0);
    chk("R1 sclk in reset", sclk, 0);
    push_exp("R1 clear", '0, CB, 1'b1);
    push_exp("R1 initial zeros", '0, FB, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 blank after reset", blank, 1);

    wait_run_start();             // zeros frame shifting
    wait_run_start();             // zeros latched, nothing pending
    wr(0, 12'hABC); wr(15, 12'h123); wr(7, 12'hFFF); wr(8, 12'h001);
    end_batch("R6 batch A", 1);
    wait_run_start();             // frame A shifting
    // R9: writes while frame A is on the wire belong to the next frame
    wr(0, 12'h555); wr(3, 12'h9A6);
    end_batch("R9 batch B", 1);
    wait_run_start();
    // R8: out-of-range indices only
    wr(16, 12'hFFF); wr(200, 12'h777);
    end_batch("R8", 0);
    wait_run_start();
    wait_run_start();
    chk("R8 no latch after ignored writes", xlat_cnt, 4);
    chk("R5 queue drained", exp_frame_q.size(), 0);
    for (int i = 0; i < NO; i++) wr(i, 12'(i * 12'h111 + 12'h00F));
    end_batch("R3 full pattern", 1);
    wait_run_start();
    wait_run_start();
    mode_alt = 1'b1; tb_alt = 1;  // R7
    wait_run_start();
    wr(5, 12'h7E1);
    end_batch("R7 batch D", 0);
    wait_run_start();
    wait_run_start();
    mode_alt = 1'b0; tb_alt = 0;
    wait_run_start();
    wait_run_start();
    wait_run_start();
    chk("R5 no latch without writes", xlat_cnt, 8);
    wr(9, 12'h3C5);
    end_batch("R6 batch E", 1);
    wait_run_start();
    wait_run_start();
    chk("R6 latch count", xlat_cnt, 9);
    chk("R6 queue drained", exp_frame_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule